// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds several physical copies of one register, one copy for each hardware unit, and all of them answer at a single bus address. A separate steering selector, at its own address, holds a group number, an instance number and a broadcast flag. Writes to the shared address go either to every copy or to the one copy that group and instance pick out. Reads of the shared address always return one picked copy, whatever the broadcast flag says.

An availability mask from fuse or power-gating logic marks each copy as live or terminated. An access steered to a terminated copy ends quietly: a read returns zero and a directed write is dropped. A broadcast write also skips terminated copies. The bus is a simple valid/ready request channel that never stalls. Each read gets a registered response one cycle after it is accepted.

Top module: `repl_reg_bank`

## Requirements
- R1: A write to any address other than the shared address or the selector address changes nothing. A read of such an address returns zero.
- R2: With the broadcast flag set, a write to the shared address loads the written value into every available copy in the same clock edge.
- R3: With the broadcast flag clear, a write to the shared address loads only copy number group*INST_PER_GROUP+instance. All other copies keep their values.
- R4: A read of the shared address returns the copy picked by group and instance. The broadcast flag does not change which copy is returned.
- R5: A read is terminated and returns zero in three cases: the picked copy has its availability bit low, the instance is INST_PER_GROUP or more, or the flat index is NUM_COPIES or more.
- R6: A directed write to a terminated copy is dropped with no response. A copy whose availability bit is low is never changed, including by a broadcast write.
- R7: The selector layout is: bit 31 is the broadcast flag, bits 27:24 are the group and bits 19:16 are the instance. All other bits read back as zero. Writing back a value that was read earlier restores the same steering.
- R8: After reset the selector reads 0x80000000 (broadcast, group 0, instance 0) and every copy holds zero.
- R9: req_ready is always high. A read accepted at one clock edge raises rsp_valid for exactly the next cycle, with its data. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high, the bank never stalls |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| avail_mask | input | NUM_COPIES | One bit per copy, 1 = live, 0 = terminated |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The assertions assume that avail_mask holds still across each clock edge, and that req_write and req_addr are known whenever req_valid is high. Under that assumption, a copy whose mask bit is low at an edge can be treated as frozen at that edge. The stimulus changes the mask only at falling edges and drives every request field, together with req_valid, from the same falling edge. Steering values beyond the implemented copies are entered through the selector's normal fields, so the out-of-range paths are exercised without any illegal encoding.

// File: rtl/repl_pkg.sv
package repl_pkg;
  localparam int unsigned SEL_W     = 32;
  localparam int unsigned MC_BIT    = 31;
  localparam int unsigned GRP_LSB   = 24;
  localparam int unsigned INST_LSB  = 16;
  localparam int unsigned FIELD_W   = 4;

  typedef struct packed {
    logic               mc;
    logic [FIELD_W-1:0] grp;
    logic [FIELD_W-1:0] inst;
  } steer_t;

  function automatic steer_t unpack_sel(input logic [SEL_W-1:0] w);
    steer_t s;
    s.mc   = w[MC_BIT];
    s.grp  = w[GRP_LSB +: FIELD_W];
    s.inst = w[INST_LSB +: FIELD_W];
    return s;
  endfunction

  function automatic logic [SEL_W-1:0] pack_sel(input steer_t s);
    logic [SEL_W-1:0] w;
    w = '0;
    w[MC_BIT]              = s.mc;
    w[GRP_LSB +: FIELD_W]  = s.grp;
    w[INST_LSB +: FIELD_W] = s.inst;
    return w;
  endfunction

  function automatic int unsigned flat_idx(input int unsigned g, input int unsigned i,
                                           input int unsigned per_grp);
    return g * per_grp + i;
  endfunction
endpackage

// File: rtl/steer_decode.sv
module steer_decode
  import repl_pkg::*;
#(
  parameter int unsigned NUM_COPIES     = 12,
  parameter int unsigned INST_PER_GROUP = 4,
  localparam int unsigned IDX_W = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_wr,
  input  logic [SEL_W-1:0]      wdata,
  input  logic [NUM_COPIES-1:0] avail,
  output steer_t                sel_q,
  output logic [IDX_W-1:0]      idx,
  output logic                  term
);
  int unsigned flat;
  logic        in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q.mc   <= 1'b1;
      sel_q.grp  <= '0;
      sel_q.inst <= '0;
    end else if (sel_wr) begin
      sel_q <= unpack_sel(wdata);
    end
  end

  always_comb begin
    flat     = flat_idx(int'(sel_q.grp), int'(sel_q.inst), INST_PER_GROUP);
    in_range = (int'(sel_q.inst) < INST_PER_GROUP) && (flat < NUM_COPIES);
    idx      = in_range ? IDX_W'(flat) : '0;
    term     = !in_range || !avail[idx];
  end

  // R7
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_q.mc == $past(wdata[MC_BIT]) &&
                sel_q.grp == $past(wdata[GRP_LSB +: FIELD_W]) &&
                sel_q.inst == $past(wdata[INST_LSB +: FIELD_W])));
  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q));
endmodule

// File: rtl/copy_store.sv
module copy_store #(
  parameter int unsigned NUM_COPIES = 12,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned IDX_W = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_all,
  input  logic                                 wr_one,
  input  logic [IDX_W-1:0]                     idx,
  input  logic [DATA_W-1:0]                    wdata,
  input  logic [NUM_COPIES-1:0]                avail,
  output logic [NUM_COPIES-1:0][DATA_W-1:0]    q
);
  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_copy
    logic load;
    assign load = avail[k] && (wr_all || (wr_one && idx == IDX_W'(k)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[k] <= '0;
      else if (load) q[k] <= wdata;
    end

    // R2
    mc_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_all && avail[k]) |=> q[k] == $past(wdata));
    // R6
    fenced_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !avail[k] |=> $stable(q[k]));
  end
endmodule

// File: rtl/repl_reg_bank.sv
module repl_reg_bank
  import repl_pkg::*;
#(
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned NUM_COPIES     = 12,
  parameter int unsigned INST_PER_GROUP = 4,
  parameter logic [ADDR_W-1:0] SHARED_ADDR = 16'h0B10,
  parameter logic [ADDR_W-1:0] SEL_ADDR    = 16'h0FD0,
  localparam int unsigned IDX_W = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [NUM_COPIES-1:0] avail_mask,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata
);
  steer_t                           sel_q;
  logic [IDX_W-1:0]                 idx;
  logic                             term;
  logic [NUM_COPIES-1:0][DATA_W-1:0] copies;
  logic [DATA_W-1:0]                rd_next;

  // named events
  logic hit_shr, hit_sel, rd_ev, sel_wr_ev, mc_wr_ev, uc_wr_ev, uc_drop_ev;

  assign req_ready  = 1'b1;
  assign hit_shr    = (req_addr == SHARED_ADDR);
  assign hit_sel    = (req_addr == SEL_ADDR);
  assign rd_ev      = req_valid && !req_write;
  assign sel_wr_ev  = req_valid && req_write && hit_sel;
  assign mc_wr_ev   = req_valid && req_write && hit_shr && sel_q.mc;
  assign uc_wr_ev   = req_valid && req_write && hit_shr && !sel_q.mc && !term;
  assign uc_drop_ev = req_valid && req_write && hit_shr && !sel_q.mc && term;

  steer_decode #(
    .NUM_COPIES(NUM_COPIES), .INST_PER_GROUP(INST_PER_GROUP)
  ) u_steer (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr_ev), .wdata(req_wdata[SEL_W-1:0]),
    .avail(avail_mask), .sel_q(sel_q), .idx(idx), .term(term)
  );

  copy_store #(
    .NUM_COPIES(NUM_COPIES), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_all(mc_wr_ev), .wr_one(uc_wr_ev), .idx(idx),
    .wdata(req_wdata), .avail(avail_mask), .q(copies)
  );

  always_comb begin
    if (hit_shr)      rd_next = term ? '0 : copies[idx];
    else if (hit_sel) rd_next = DATA_W'(pack_sel(sel_q));
    else              rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_ev;
      if (rd_ev) rsp_rdata <= rd_next;
    end
  end

  // R9
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> rsp_valid);
  // R9
  rsp_only_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> !rsp_valid);
  // R5
  term_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && hit_shr && term) |=> rsp_rdata == '0);
  // R4
  steered_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && hit_shr && !term) |=> rsp_rdata == $past(copies[idx]));
  // R6
  uc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uc_drop_ev |=> $stable(copies));
  // R1
  stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !hit_shr && !hit_sel) |=> ($stable(copies) && $stable(sel_q)));
endmodule

// File: tb/sim_repl_reg_bank.sv
module sim_repl_reg_bank;
  localparam int NC = 12;
  localparam int IPG = 4;
  localparam logic [15:0] A_SHR = 16'h0B10;
  localparam logic [15:0] A_SEL = 16'h0FD0;
  localparam logic [15:0] A_OTH = 16'h0200;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [NC-1:0] avail_mask = 12'hF7B;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;
  string cur_tag = "R8";

  // reference model
  int unsigned m_mc, m_g, m_i;
  logic [31:0] m_copy [NC];
  bit pred_valid = 0;
  logic [31:0] pred_data = '0;
  string pred_tag = "";

  always #4 clk = ~clk;

  repl_reg_bank u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .avail_mask(avail_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] sv(int unsigned mc, int unsigned g, int unsigned i);
    return (32'(mc) << 31) | (32'(g) << 24) | (32'(i) << 16);
  endfunction

  function automatic bit live(output int unsigned n);
    n = m_g * IPG + m_i;
    return (m_i < IPG) && (n < NC) && avail_mask[n];
  endfunction

  function automatic logic [31:0] model_rd(logic [15:0] a);
    int unsigned n;
    if (a == A_SEL) return sv(m_mc, m_g, m_i);
    if (a == A_SHR) return live(n) ? m_copy[n] : 32'h0;
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mc = 1; m_g = 0; m_i = 0;
      foreach (m_copy[k]) m_copy[k] = '0;
      pred_valid = 0;
    end else begin
      pred_valid = req_valid && !req_write;
      if (pred_valid) begin
        pred_data = model_rd(req_addr);
        pred_tag = cur_tag;
      end
      if (req_valid && req_write) begin
        if (req_addr == A_SEL) begin
          m_mc = req_wdata[31]; m_g = req_wdata[27:24]; m_i = req_wdata[19:16];
        end else if (req_addr == A_SHR) begin
          int unsigned n;
          if (m_mc != 0) begin
            for (int k = 0; k < NC; k++) if (avail_mask[k]) m_copy[k] = req_wdata;
          end else if (live(n)) m_copy[n] = req_wdata;
        end
      end
    end
  end

  // compare on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready === 1'b1, "R9 ready", 32'(req_ready), 32'h1);
      chk(rsp_valid === pred_valid, "R9 rsp_valid", 32'(rsp_valid), 32'(pred_valid));
      if (pred_valid)
        chk(rsp_rdata === pred_data, pred_tag, rsp_rdata, pred_data);
    end
  end

  task automatic op(bit w, logic [15:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  initial begin
    #(8 * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    op(0, A_SEL, 0, "R8 selector reset");
    op(0, A_SHR, 0, "R8 copy reset");
    // R2 broadcast write, copies 2 and 7 unavailable
    op(1, A_SHR, 32'hA5A5_0001, "R2");
    op(1, A_SEL, sv(1, 0, 1), "R7");
    op(0, A_SHR, 0, "R4 read with broadcast set");
    op(1, A_SEL, sv(1, 0, 2), "R7");
    op(0, A_SHR, 0, "R5 unavailable copy");
    // R6 directed write to terminated copy 7
    op(1, A_SEL, sv(0, 1, 3), "R7");
    op(1, A_SHR, 32'hDEAD_0007, "R6");
    op(0, A_SHR, 0, "R5 terminated read");
    @(negedge clk) avail_mask = 12'hFFF;
    op(0, A_SHR, 0, "R6 copy 7 untouched");
    // R3 directed write to copy 8, neighbours untouched
    op(1, A_SEL, sv(0, 2, 0), "R7");
    op(1, A_SHR, 32'h0000_1234, "R3");
    op(0, A_SHR, 0, "R3 target");
    op(1, A_SEL, sv(0, 2, 1), "R7");
    op(0, A_SHR, 0, "R3 neighbour");
    op(1, A_SEL, sv(1, 2, 0), "R7");
    op(0, A_SHR, 0, "R4 same copy broadcast set");
    // R5 out of range index and instance
    op(1, A_SEL, sv(0, 3, 1), "R7");
    op(1, A_SHR, 32'h5555_AAAA, "R6 out of range");
    op(0, A_SHR, 0, "R5 index beyond copies");
    op(1, A_SEL, sv(0, 0, 5), "R7");
    op(1, A_SHR, 32'h1111_2222, "R6 bad instance");
    op(0, A_SHR, 0, "R5 instance beyond group");
    op(1, A_SEL, sv(0, 1, 1), "R7");
    op(0, A_SHR, 0, "R5 alias target unchanged");
    // R1 stray address
    op(1, A_OTH, 32'hFFFF_FFFF, "R1");
    op(0, A_OTH, 0, "R1 stray read");
    op(0, A_SEL, 0, "R1 selector unchanged");
    op(0, A_SHR, 0, "R1 copy unchanged");
    // R7 readback masks reserved bits, restore
    op(1, A_SEL, 32'hFFFF_FFFF, "R7");
    op(0, A_SEL, 0, "R7 readback masked");
    op(1, A_SEL, sv(0, 2, 0), "R7");
    op(0, A_SEL, 0, "R7 restore");
    op(0, A_SHR, 0, "R7 restored steering");
    // back-to-back reads
    @(negedge clk);
    cur_tag = "R9 back to back";
    req_valid = 1; req_write = 0; req_addr = A_SHR;
    @(negedge clk);
    req_addr = A_SEL;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule